// File: doc/BRIEF.md
# Voltage-Drop Charge Termination Detector

This block ends the fast-charge phase of a nickel-chemistry cell charger by watching the voltage fall back from its highest point. Upstream logic delivers averaged cell-voltage samples in millivolt codes, one per valid strobe. The block keeps the largest sample seen since the last history reset. It raises a sticky terminate flag when a new sample lands far enough below that peak.

The allowed drop depends on the selected mode. The large-drop mode (nominally 12 mV) suits cells that show a pronounced voltage fall at full charge. The small-drop mode (nominally 3 mV) catches a plateau or a slight roll-off. Drop tests are only made for samples strictly inside a 1.0 V to 2.0 V window, and never while the hold-off input is asserted. The hold-off covers the voltage spikes seen at the start of fast charge. A history-clear strobe drops the held peak and the flag, so that tracking restarts from the next usable sample.

Top module: `vdrop_term_det`

## Requirements
- R1: After reset, term_o is 0 and no peak is held.
- R2: mode_i with bit 1 set (2'b10 high or 2'b11) selects large-drop mode. A valid sample at least NDV_DROP_MV (default 12) below the held peak sets term_o one clock later. A drop of 11 does not set it.
- R3: mode_i 2'b00 (low) or 2'b01 (mid) selects small-drop mode. A drop of at least PVD_DROP_MV (default 3) sets term_o, and a drop of 2 does not.
- R4: Only samples with WIN_LO_MV < sample_i < WIN_HI_MV (defaults 1000 and 2000) are used. Other samples neither set term_o nor change or load the peak.
- R5: While holdoff_i is 1, no sample sets term_o.
- R6: clear_i clears term_o on the next clock and discards the held peak.
- R7: The first in-window valid sample after reset or clear loads the peak and never sets term_o.
- R8: Any in-window valid sample above the held peak replaces it, including samples taken during hold-off.
- R9: Once set, term_o stays 1 until clear_i or reset.
- R10: When clear_i and sample_vld_i are high in the same cycle, the clear wins and that sample is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sample_vld_i | input | 1 | Sample strobe, one cycle per sample |
| sample_i | input | SAMPLE_W | Averaged cell voltage in mV |
| mode_i | input | 2 | Three-level mode: 00 low, 01 mid, 1x high |
| holdoff_i | input | 1 | Suppresses drop termination |
| clear_i | input | 1 | History and flag clear |
| term_o | output | 1 | Registered sticky terminate flag |

## Verification
Peak updates made under hold-off are the hardest case to expose, because no flag moves while hold-off is up. The bench raises the peak during hold-off, then releases it and probes with samples just short of and exactly at the threshold below the new peak. Only a peak that really moved produces the flag at the second probe. Out-of-window samples and a clear that coincides with a sample are exposed the same way. After each, a follow-up sample would terminate only if the ignored sample had changed the peak.

// File: rtl/vdrop_pkg.sv
package vdrop_pkg;
  typedef enum logic {
    DET_PEAK = 1'b0,
    DET_NDV  = 1'b1
  } det_mode_e;

  function automatic det_mode_e decode_mode(input logic [1:0] lvl);
    return lvl[1] ? DET_NDV : DET_PEAK;
  endfunction
endpackage

// File: rtl/vdrop_mode_sel.sv
module vdrop_mode_sel
  import vdrop_pkg::*;
#(
  parameter int unsigned THR_W       = 8,
  parameter int unsigned NDV_DROP_MV = 12,
  parameter int unsigned PVD_DROP_MV = 3
) (
  input  logic [1:0]       mode_i,
  output det_mode_e        mode_o,
  output logic [THR_W-1:0] thr_o
);
  always_comb begin
    mode_o = decode_mode(mode_i);
    thr_o  = (mode_o == DET_NDV) ? THR_W'(NDV_DROP_MV) : THR_W'(PVD_DROP_MV);
  end
endmodule

// File: rtl/vdrop_window.sv
module vdrop_window #(
  parameter int unsigned SAMPLE_W  = 12,
  parameter int unsigned WIN_LO_MV = 1000,
  parameter int unsigned WIN_HI_MV = 2000
) (
  input  logic [SAMPLE_W-1:0] sample_i,
  output logic                in_win_o
);
  localparam logic [SAMPLE_W-1:0] LO = SAMPLE_W'(WIN_LO_MV);
  localparam logic [SAMPLE_W-1:0] HI = SAMPLE_W'(WIN_HI_MV);

  assign in_win_o = (sample_i > LO) && (sample_i < HI);
endmodule

// File: rtl/vdrop_peak_track.sv
module vdrop_peak_track #(
  parameter int unsigned SAMPLE_W = 12
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clear_i,
  input  logic                take_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  output logic [SAMPLE_W-1:0] peak_o,
  output logic                peak_vld_o
);
  logic [SAMPLE_W-1:0] peak_q;
  logic                vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      peak_q <= '0;
      vld_q  <= 1'b0;
    end else if (clear_i) begin
      peak_q <= '0;
      vld_q  <= 1'b0;
    end else if (take_i && (!vld_q || sample_i > peak_q)) begin
      peak_q <= sample_i;
      vld_q  <= 1'b1;
    end
  end

  assign peak_o     = peak_q;
  assign peak_vld_o = vld_q;
endmodule

// File: rtl/vdrop_drop_cmp.sv
module vdrop_drop_cmp #(
  parameter int unsigned SAMPLE_W = 12,
  parameter int unsigned THR_W    = 8
) (
  input  logic                peak_vld_i,
  input  logic [SAMPLE_W-1:0] peak_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic [THR_W-1:0]    thr_i,
  output logic                hit_o
);
  localparam int unsigned DW = (SAMPLE_W > THR_W) ? SAMPLE_W + 1 : THR_W + 1;

  logic [DW-1:0] diff;

  always_comb begin
    diff  = DW'(peak_i) - DW'(sample_i);
    hit_o = peak_vld_i && (peak_i > sample_i) && (diff >= DW'(thr_i));
  end
endmodule

// File: rtl/vdrop_term_det.sv
module vdrop_term_det
  import vdrop_pkg::*;
#(
  parameter int unsigned SAMPLE_W    = 12,
  parameter int unsigned WIN_LO_MV   = 1000,
  parameter int unsigned WIN_HI_MV   = 2000,
  parameter int unsigned NDV_DROP_MV = 12,
  parameter int unsigned PVD_DROP_MV = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sample_vld_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic [1:0]          mode_i,
  input  logic                holdoff_i,
  input  logic                clear_i,
  output logic                term_o
);
  localparam int unsigned MAX_THR = (NDV_DROP_MV > PVD_DROP_MV) ? NDV_DROP_MV : PVD_DROP_MV;
  localparam int unsigned THR_W   = $clog2(MAX_THR + 1);

  det_mode_e           mode;
  logic [THR_W-1:0]    thr;
  logic                in_win;
  logic                take;
  logic [SAMPLE_W-1:0] peak_q;
  logic                peak_vld_q;
  logic                drop_hit;
  logic                fire;
  logic                term_q;

  vdrop_mode_sel #(
    .THR_W      (THR_W),
    .NDV_DROP_MV(NDV_DROP_MV),
    .PVD_DROP_MV(PVD_DROP_MV)
  ) mode_sel_i (
    .mode_i(mode_i),
    .mode_o(mode),
    .thr_o (thr)
  );

  vdrop_window #(
    .SAMPLE_W (SAMPLE_W),
    .WIN_LO_MV(WIN_LO_MV),
    .WIN_HI_MV(WIN_HI_MV)
  ) window_i (
    .sample_i(sample_i),
    .in_win_o(in_win)
  );

  assign take = sample_vld_i && in_win && !clear_i;

  vdrop_peak_track #(
    .SAMPLE_W(SAMPLE_W)
  ) peak_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (clear_i),
    .take_i    (take),
    .sample_i  (sample_i),
    .peak_o    (peak_q),
    .peak_vld_o(peak_vld_q)
  );

  vdrop_drop_cmp #(
    .SAMPLE_W(SAMPLE_W),
    .THR_W   (THR_W)
  ) cmp_i (
    .peak_vld_i(peak_vld_q),
    .peak_i    (peak_q),
    .sample_i  (sample_i),
    .thr_i     (thr),
    .hit_o     (drop_hit)
  );

  assign fire = take && !holdoff_i && drop_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      term_q <= 1'b0;
    else if (clear_i) term_q <= 1'b0;
    else if (fire)    term_q <= 1'b1;
  end

  assign term_o = term_q;

  logic unused_mode;
  assign unused_mode = (mode == DET_NDV);
endmodule

// File: rtl/vdrop_term_det_chk.sv
module vdrop_term_det_chk #(
  parameter int unsigned SAMPLE_W    = 12,
  parameter int unsigned WIN_LO_MV   = 1000,
  parameter int unsigned WIN_HI_MV   = 2000,
  parameter int unsigned PVD_DROP_MV = 3,
  parameter int unsigned NDV_DROP_MV = 12
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                sample_vld_i,
  input logic [SAMPLE_W-1:0] sample_i,
  input logic                holdoff_i,
  input logic                clear_i,
  input logic                term_o,
  input logic [SAMPLE_W-1:0] peak_q,
  input logic                peak_vld_q
);
  localparam int unsigned MIN_THR = (PVD_DROP_MV < NDV_DROP_MV) ? PVD_DROP_MV : NDV_DROP_MV;

  a_r1_reset_clear: assert property (@(posedge clk_i) !rst_ni |=> !term_o);

  a_r5_no_fire_holdoff: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(term_o) |-> $past(!holdoff_i && sample_vld_i && !clear_i));

  a_r4_fire_in_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(term_o) |-> ($past(sample_i) > SAMPLE_W'(WIN_LO_MV) && $past(sample_i) < SAMPLE_W'(WIN_HI_MV)));

  a_r7_first_no_fire: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(term_o) |-> $past(peak_vld_q));

  a_r2_r3_min_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(term_o) |-> ({1'b0, $past(peak_q)} >= {1'b0, $past(sample_i)} + (SAMPLE_W+1)'(MIN_THR)));

  a_r9_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (term_o && !clear_i) |=> term_o);

  a_r6_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (!term_o && !peak_vld_q));

  a_r8_peak_monotonic: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (peak_vld_q && !clear_i) |=> (peak_vld_q && peak_q >= $past(peak_q)));
endmodule

bind vdrop_term_det vdrop_term_det_chk #(
  .SAMPLE_W   (SAMPLE_W),
  .WIN_LO_MV  (WIN_LO_MV),
  .WIN_HI_MV  (WIN_HI_MV),
  .PVD_DROP_MV(PVD_DROP_MV),
  .NDV_DROP_MV(NDV_DROP_MV)
) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sample_vld_i(sample_vld_i),
  .sample_i    (sample_i),
  .holdoff_i   (holdoff_i),
  .clear_i     (clear_i),
  .term_o      (term_o),
  .peak_q      (peak_q),
  .peak_vld_q  (peak_vld_q)
);

// File: tb/vdrop_term_det_tb_top.sv
module vdrop_term_det_tb_top;
  localparam int unsigned SW = 12;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          sample_vld_i = 1'b0;
  logic [SW-1:0] sample_i = '0;
  logic [1:0]    mode_i = 2'b10;
  logic          holdoff_i = 1'b0;
  logic          clear_i = 1'b0;
  logic          term_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  vdrop_term_det dut_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sample_vld_i(sample_vld_i),
    .sample_i    (sample_i),
    .mode_i      (mode_i),
    .holdoff_i   (holdoff_i),
    .clear_i     (clear_i),
    .term_o      (term_o)
  );

  task automatic expect_term(input string req, input logic exp);
    checks++;
    if (term_o !== exp) begin
      errors++;
      $display("FAIL %s: term_o actual %b expected %b", req, term_o, exp);
    end
  endtask

  // one-cycle sample, returns after the registered flag has settled
  task automatic send(input int unsigned mv);
    @(negedge clk_i);
    sample_vld_i = 1'b1;
    sample_i     = SW'(mv);
    @(negedge clk_i);
    sample_vld_i = 1'b0;
  endtask

  task automatic do_clear();
    @(negedge clk_i);
    clear_i = 1'b1;
    @(negedge clk_i);
    clear_i = 1'b0;
  endtask

  task automatic t_reset();
    expect_term("R1", 1'b0);
  endtask

  task automatic t_large_drop();
    do_clear();
    mode_i = 2'b10;
    send(1500); expect_term("R7", 1'b0);
    send(1520); expect_term("R8", 1'b0);
    send(1509); expect_term("R2", 1'b0);
    send(1508); expect_term("R2", 1'b1);
    send(1600); expect_term("R9", 1'b1);
    do_clear(); expect_term("R6", 1'b0);
  endtask

  task automatic t_small_drop();
    do_clear();
    mode_i = 2'b00;
    send(1400);
    send(1398); expect_term("R3", 1'b0);
    send(1397); expect_term("R3", 1'b1);
    do_clear();
    mode_i = 2'b01;
    send(1400);
    send(1397); expect_term("R3", 1'b1);
    do_clear();
    mode_i = 2'b11;
    send(1400);
    send(1390); expect_term("R2", 1'b0);
    send(1388); expect_term("R2", 1'b1);
  endtask

  task automatic t_fresh_history();
    do_clear();
    mode_i = 2'b00;
    send(1400);
    do_clear();
    send(1200); expect_term("R6", 1'b0);
    send(1198); expect_term("R7", 1'b0);
    send(1197); expect_term("R6", 1'b1);
  endtask

  task automatic t_window();
    do_clear();
    mode_i = 2'b10;
    send(1500);
    send(1000); expect_term("R4", 1'b0);
    send(990);  expect_term("R4", 1'b0);
    send(2000); expect_term("R4", 1'b0);
    send(1495); expect_term("R4", 1'b0);
    send(1488); expect_term("R4", 1'b1);
    do_clear();
    mode_i = 2'b00;
    send(1999);
    send(1996); expect_term("R4", 1'b1);
  endtask

  task automatic t_holdoff();
    do_clear();
    mode_i = 2'b10;
    holdoff_i = 1'b1;
    send(1500);
    send(1600);
    send(1400); expect_term("R5", 1'b0);
    holdoff_i = 1'b0;
    send(1590); expect_term("R8", 1'b0);
    send(1588); expect_term("R8", 1'b1);
  endtask

  task automatic t_clear_wins();
    @(negedge clk_i);
    mode_i       = 2'b10;
    clear_i      = 1'b1;
    sample_vld_i = 1'b1;
    sample_i     = SW'(1300);
    @(negedge clk_i);
    clear_i      = 1'b0;
    sample_vld_i = 1'b0;
    expect_term("R10", 1'b0);
    send(1287); expect_term("R10", 1'b0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_large_drop();
    t_small_drop();
    t_fresh_history();
    t_window();
    t_holdoff();
    t_clear_wins();
    repeat (2) @(negedge clk_i);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    checks++;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end
endmodule